// File: doc/BRIEF.md
# RGB Panel Dot-Clock Timing Generator

This block produces the raster timing for a parallel RGB panel that is clocked one pixel per dot clock. Two counters track the dot position within a line and the line position within a frame. From a set of programmed counts the block derives a horizontal sync pulse, a vertical sync pulse and a data-enable window, and it reports the active pixel's X and Y coordinates. A one-cycle start-of-frame strobe marks the frame boundary, so that a buffer swap elsewhere can be timed to it.

All horizontal quantities are in dot clocks and all vertical quantities are in whole lines. Both wait counts are measured from the first cycle of the matching sync pulse, so they already include the sync width. The sync outputs have their own enable, separate from the run enable that opens the data window. Software is expected to turn the sync outputs on before it sets run. Each of hsync, vsync and data enable has its own polarity bit. A fourth bit selects the dot-clock edge on which data is launched, and it is presented on an output for the clock and pad logic.

The timing counts and the launch-edge bit are copied into shadow registers only at the end of a frame, or while the block is idle. A reprogram in the middle of a frame therefore takes effect at the next frame. Totals must be at least 2, and each wait plus active count must not exceed its total.

Top module: `rgb_timing_gen`

## Requirements
- R1: While either enable is set, the dot counter runs from 0 to `h_total`-1 and then wraps. Each line is therefore exactly `h_total` dot clocks long.
- R2: Horizontal sync is active for the first `h_sync_len` dot clocks of every line.
- R3: The horizontal active window covers dot positions `h_wait` through `h_wait`+`h_active`-1, counted from the start of hsync. Inside the window, `pix_x` equals the dot position minus `h_wait`.
- R4: A frame is `v_total` lines long. Vertical sync is active for the first `v_sync_len` whole lines of the frame.
- R5: The vertical active window covers lines `v_wait` through `v_wait`+`v_active`-1. Inside the window, `pix_y` equals the line number minus `v_wait`.
- R6: Each of `hs_high`, `vs_high` and `de_high` sets its output's active level: 1 means active-high and 0 means active-low.
- R7: When `sync_en` is clear, `hsync` and `vsync` sit at their inactive levels. When both enables are clear, the counters are held at zero.
- R8: When `run_en` is clear, `pix_valid` is 0, `de` is inactive, and `pix_x` and `pix_y` are 0.
- R9: `sof` is high for exactly one dot clock at the first dot of every frame. This cycle is the leading edge of vsync.
- R10: A change to any timing count during a frame leaves the rest of that frame unchanged. The new counts apply from the first dot of the next frame.
- R11: `launch_fall_q` shows the programmed launch-edge bit. It is updated under the same frame-boundary rule as the timing counts.
- R12: After reset, with both enables clear, all sync and enable outputs are inactive and `sof` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Opens the data-enable window |
| sync_en | input | 1 | Drives the sync outputs |
| h_sync_len | input | HW | Hsync width in dot clocks |
| h_wait | input | HW | Dots from hsync start to first active dot |
| h_active | input | HW | Active pixels per line |
| h_total | input | HW | Line period in dot clocks |
| v_sync_len | input | VW | Vsync width in lines |
| v_wait | input | VW | Lines from vsync start to first active line |
| v_active | input | VW | Active lines per frame |
| v_total | input | VW | Frame period in lines |
| hs_high | input | 1 | Hsync active-high select |
| vs_high | input | 1 | Vsync active-high select |
| de_high | input | 1 | Data-enable active-high select |
| launch_fall | input | 1 | Launch data on the falling dot-clock edge |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pix_valid | output | 1 | Active-high pixel-valid flag |
| pix_x | output | HW | Active pixel column |
| pix_y | output | VW | Active pixel row |
| sof | output | 1 | Start-of-frame strobe |
| launch_fall_q | output | 1 | Launch-edge select in effect |

## Verification
The raster is run under two geometries with different sync widths, margins and windows, so that swapped or misaligned wait and width counts show up. All outputs are compared every cycle, over whole frames, in several setups:

- All polarities high, then all polarities low, which separates the level selection from the timing.
- Sync only and run only, which show that each enable gates only its own outputs.
- A reprogram in the middle of a frame. The expected raster keeps the old geometry up to the frame end and switches exactly at the next start-of-frame, which exposes both early and late shadow loading.

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          sync_en,
  input  logic [HW-1:0] h_sync_len,
  input  logic [HW-1:0] h_wait,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_sync_len,
  input  logic [VW-1:0] v_wait,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] v_total,
  input  logic          hs_high,
  input  logic          vs_high,
  input  logic          de_high,
  input  logic          launch_fall,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pix_valid,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] pix_y,
  output logic          sof,
  output logic          launch_fall_q
);

  logic [HW-1:0] hcnt, hsl_s, hwt_s, hac_s, htot_s;
  logic [VW-1:0] vcnt, vsl_s, vwt_s, vac_s, vtot_s;
  logic          edge_s;

  wire go        = run_en | sync_en;
  wire line_end  = (hcnt == htot_s - 1'b1);
  wire frame_end = line_end && (vcnt == vtot_s - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsl_s <= '0; hwt_s <= '0; hac_s <= '0; htot_s <= '0;
      vsl_s <= '0; vwt_s <= '0; vac_s <= '0; vtot_s <= '0;
      edge_s <= 1'b0;
    end else if (!go || frame_end) begin
      hsl_s <= h_sync_len; hwt_s <= h_wait; hac_s <= h_active; htot_s <= h_total;
      vsl_s <= v_sync_len; vwt_s <= v_wait; vac_s <= v_active; vtot_s <= v_total;
      edge_s <= launch_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!go) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  wire h_in = (hcnt >= hwt_s) && ({1'b0, hcnt} < ({1'b0, hwt_s} + {1'b0, hac_s}));
  wire v_in = (vcnt >= vwt_s) && ({1'b0, vcnt} < ({1'b0, vwt_s} + {1'b0, vac_s}));
  wire hs_act = sync_en && (hcnt < hsl_s);
  wire vs_act = sync_en && (vcnt < vsl_s);

  assign pix_valid     = run_en && h_in && v_in;
  assign hsync         = ~(hs_act ^ hs_high);
  assign vsync         = ~(vs_act ^ vs_high);
  assign de            = ~(pix_valid ^ de_high);
  assign pix_x         = pix_valid ? hcnt - hwt_s : '0;
  assign pix_y         = pix_valid ? vcnt - vwt_s : '0;
  assign sof           = go && (hcnt == '0) && (vcnt == '0);
  assign launch_fall_q = edge_s;

  a_r1_hcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (go && htot_s >= 2) |-> (hcnt < htot_s));

  a_r7_sync_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |-> (hsync != hs_high) && (vsync != vs_high));

  a_r8_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (!pix_valid && de != de_high && pix_x == '0));

  a_r9_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && htot_s >= 2) |=> !sof);

  a_r9_sof_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && sync_en && vsl_s != '0) |-> (vsync == vs_high));

  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !frame_end) |=> ($stable(htot_s) && $stable(vtot_s) && $stable(hwt_s) && $stable(vwt_s)));

endmodule

// File: tb/tb_rgb_timing_gen.sv
module tb_rgb_timing_gen;
  localparam int HW = 12;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, sync_en = 1'b0;
  logic [HW-1:0] h_sync_len = '0, h_wait = '0, h_active = '0, h_total = '0;
  logic [VW-1:0] v_sync_len = '0, v_wait = '0, v_active = '0, v_total = '0;
  logic hs_high = 1'b1, vs_high = 1'b1, de_high = 1'b1, launch_fall = 1'b0;
  logic hsync, vsync, de, pix_valid, sof, launch_fall_q;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;

  always #4 clk = ~clk;

  rgb_timing_gen #(.HW(HW), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .sync_en(sync_en),
    .h_sync_len(h_sync_len), .h_wait(h_wait), .h_active(h_active), .h_total(h_total),
    .v_sync_len(v_sync_len), .v_wait(v_wait), .v_active(v_active), .v_total(v_total),
    .hs_high(hs_high), .vs_high(vs_high), .de_high(de_high), .launch_fall(launch_fall),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .sof(sof), .launch_fall_q(launch_fall_q));

  typedef struct packed {
    logic hs, vs, de, pv, sof, lf;
    logic [HW-1:0] x;
    logic [VW-1:0] y;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  bit done = 1'b0;
  string seg_tag = "";

  // geometry table: hsl, hwait, hact, htot, vsl, vwait, vact, vtot, launch edge
  int geo [2][9] = '{'{3, 5, 10, 20, 2, 4, 6, 12, 0},
                     '{1, 2, 12, 16, 1, 1, 6, 8, 1}};

  function automatic exp_t calc(int g, bit r, bit s, bit ph, bit pvs, bit pd, int i);
    exp_t e;
    int h, v;
    bit win, hsa, vsa;
    h   = i % geo[g][3];
    v   = (i / geo[g][3]) % geo[g][7];
    hsa = s && (h < geo[g][0]);
    vsa = s && (v < geo[g][4]);
    win = (h >= geo[g][1]) && (h < geo[g][1] + geo[g][2]) &&
          (v >= geo[g][5]) && (v < geo[g][5] + geo[g][6]);
    e.pv  = r && win;
    e.hs  = ph ? hsa : !hsa;
    e.vs  = pvs ? vsa : !vsa;
    e.de  = pd ? e.pv : !e.pv;
    e.sof = (h == 0) && (v == 0);
    e.lf  = geo[g][8][0];
    e.x   = e.pv ? HW'(h - geo[g][1]) : '0;
    e.y   = e.pv ? VW'(v - geo[g][5]) : '0;
    return e;
  endfunction

  task automatic load_geo(int g);
    h_sync_len = HW'(geo[g][0]); h_wait = HW'(geo[g][1]);
    h_active   = HW'(geo[g][2]); h_total = HW'(geo[g][3]);
    v_sync_len = VW'(geo[g][4]); v_wait = VW'(geo[g][5]);
    v_active   = VW'(geo[g][6]); v_total = VW'(geo[g][7]);
    launch_fall = geo[g][8][0];
  endtask

  task automatic check_idle(string tag);
    @(negedge clk);
    checks++;
    if (hsync != !hs_high || vsync != !vs_high || de != !de_high || pix_valid || sof) begin
      failures++;
      $display("FAIL %s idle: hs=%b vs=%b de=%b pv=%b sof=%b expected hs=%b vs=%b de=%b pv=0 sof=0",
               tag, hsync, vsync, de, pix_valid, sof, !hs_high, !vs_high, !de_high);
    end
  endtask

  // driver: pushes the expected raster, then enables the block.
  // g2 >= 0 switches geometry mid-frame at dot 'sw'; the old one holds until its frame ends.
  task automatic segment(string tag, int g, int g2, int sw, bit r, bit s,
                         bit ph, bit pvs, bit pd, int nframes);
    int flen, n;
    seg_tag = tag;
    run_en = 1'b0; sync_en = 1'b0;
    hs_high = ph; vs_high = pvs; de_high = pd;
    load_geo(g);
    repeat (2) @(posedge clk);
    #1;
    flen = geo[g][3] * geo[g][7];
    if (g2 < 0) begin
      n = flen * nframes;
      for (int i = 0; i < n; i++) q.push_back(calc(g, r, s, ph, pvs, pd, i));
    end else begin
      n = flen + geo[g2][3] * geo[g2][7] * nframes;
      for (int i = 0; i < flen; i++) q.push_back(calc(g, r, s, ph, pvs, pd, i));
      for (int i = flen; i < n; i++) q.push_back(calc(g2, r, s, ph, pvs, pd, i - flen));
    end
    run_en = r; sync_en = s;
    if (g2 >= 0) begin
      repeat (sw) @(posedge clk);
      #1 load_geo(g2);
      repeat (n - sw) @(posedge clk);
    end else begin
      repeat (n) @(posedge clk);
    end
    #1 run_en = 1'b0; sync_en = 1'b0;
    check_idle({tag, " R7"});
  endtask

  // monitor: pops one expected item per dot clock while any are queued
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = 1'b0;
        checks++;
        if (hsync != e.hs) begin bad = 1'b1;
          $display("FAIL %s R1 R2 R6 R7 hsync=%b expected %b", seg_tag, hsync, e.hs); end
        if (vsync != e.vs) begin bad = 1'b1;
          $display("FAIL %s R4 R6 R7 vsync=%b expected %b", seg_tag, vsync, e.vs); end
        if (de != e.de) begin bad = 1'b1;
          $display("FAIL %s R3 R5 R6 R8 de=%b expected %b", seg_tag, de, e.de); end
        if (pix_valid != e.pv) begin bad = 1'b1;
          $display("FAIL %s R8 pix_valid=%b expected %b", seg_tag, pix_valid, e.pv); end
        if (pix_x != e.x) begin bad = 1'b1;
          $display("FAIL %s R3 pix_x=%0d expected %0d", seg_tag, pix_x, e.x); end
        if (pix_y != e.y) begin bad = 1'b1;
          $display("FAIL %s R5 pix_y=%0d expected %0d", seg_tag, pix_y, e.y); end
        if (sof != e.sof) begin bad = 1'b1;
          $display("FAIL %s R9 sof=%b expected %b", seg_tag, sof, e.sof); end
        if (launch_fall_q != e.lf) begin bad = 1'b1;
          $display("FAIL %s R11 launch_fall_q=%b expected %b", seg_tag, launch_fall_q, e.lf); end
        if (bad) failures++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    check_idle("R12 in reset");
    #1 rst_n = 1'b1;
    check_idle("R12 after reset");
    segment("R1 R2 R3 R4 R5 geo A high pol", 0, -1, 0, 1, 1, 1, 1, 1, 2);
    segment("R6 geo A low pol", 0, -1, 0, 1, 1, 0, 0, 0, 1);
    segment("R8 sync only", 0, -1, 0, 0, 1, 1, 0, 1, 1);
    segment("R7 run only", 0, -1, 0, 1, 0, 0, 1, 0, 1);
    segment("R11 geo B", 1, -1, 0, 1, 1, 1, 1, 1, 2);
    segment("R10 reprogram mid-frame A to B", 0, 1, 100, 1, 1, 1, 1, 1, 2);
    segment("R10 reprogram mid-frame B to A", 1, 0, 37, 1, 1, 0, 1, 1, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule